// File: doc/BRIEF.md
# Blinking Sign Light Sequencer

This block runs the five lamps of a roadside warning sign. While the sign's enable switch is on, the lamps build up in a fixed pattern that repeats. The pattern starts with every lamp dark. Next, the first two lamps light. Then the first four light. Finally all five light. After that the sign goes dark again and the pattern starts over. One step of the pattern lasts a fixed time. That time comes from an internal prescaler, which counts clock cycles and gives one step tick per interval. By default the interval is half a second at the given clock frequency.

The switch is a slow, asynchronous level, so a flip-flop chain brings it into the clock domain first. When the switch turns off, every lamp goes dark. The step state and the prescaler both return to their start, so the next switch-on begins at the dark step and waits a full interval. The step state is held in two flip-flops. The lamp levels are decoded from that state and then registered, so the outputs change only at clock edges.

Top module: `blink_sign_seq`

## Requirements
- R1: While rst_n is low at a rising clock edge, `lamps` reads 5'b00000 after that edge, and the sequence restarts from the dark step.
- R2: Lamp n (n = 1..5) is bit n-1 of `lamps`. The four steps show 5'b00000 (dark), 5'b00011 (lamps 1-2), 5'b01111 (lamps 1-4) and 5'b11111 (lamps 1-5).
- R3: While the switch is on, each step tick moves the pattern to the next step in the order dark, 1-2, 1-4, 1-5, dark, and so on without end.
- R4: While the switch is on, `lamps` holds its value except on the edge that ends an interval. An interval is STEP_CYCLES = CLK_HZ/1000*STEP_MS clock edges, counted from the first edge at which the synchronized switch is seen on.
- R5: At every edge where the synchronized switch is off, `lamps` becomes 5'b00000 and the interval count restarts. The first step after the next switch-on therefore comes a full interval later.
- R6: The switch level sampled at an edge acts on the lamps SYNC_STAGES edges later. With the default of 2 stages, a level sampled at edge k decides the lamp update at edge k+2. A switch pulse of one cycle is still seen.
- R7: At no clock cycle does `lamps` hold a value other than the four codes of R2.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock; all state changes on its rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| sw_on | input | 1 | Enable switch level, asynchronous; 1 = sign running |
| lamps | output | 5 | Registered lamp levels; bit 0 is lamp 1, 1 = lit |

## Verification
The properties take for granted that reset is held for at least one edge before the switch is used. They also assume the switch only changes value between edges, so the first synchronizer flop never samples a transition. The stimulus drives the switch and the reset only at falling clock edges. It holds reset for several cycles at start and again once in mid-run. It shortens the interval by overriding the timing parameters, so that the pattern wraps several times. It also turns the switch off both mid-interval and for a single cycle.

// File: rtl/blink_sign_pkg.sv
// Package: shared types and the step-to-lamp decode for the sign sequencer.
// Assumes exactly five lamps and four pattern steps.
package blink_sign_pkg;

    localparam int LAMP_W  = 5;
    localparam int STEP_W  = 2;

    // Pattern step held in two flip-flops; order of values is the loop order.
    typedef enum logic [STEP_W-1:0] {
        STEP_DARK  = 2'd0,
        STEP_TWO   = 2'd1,
        STEP_FOUR  = 2'd2,
        STEP_FIVE  = 2'd3
    } step_e;

    // Number of lamps lit in a given step, counted from lamp 1.
    function automatic int unsigned lit_count(input step_e s);
        case (s)
            STEP_DARK: lit_count = 0;
            STEP_TWO:  lit_count = 2;
            STEP_FOUR: lit_count = 4;
            default:   lit_count = 5;
        endcase
    endfunction

    // Lamp mask: the lowest lit_count bits set.
    function automatic logic [LAMP_W-1:0] step_lamps(input step_e s);
        logic [LAMP_W-1:0] m;
        m = '0;
        for (int i = 0; i < LAMP_W; i++) begin
            if (i < int'(lit_count(s))) m[i] = 1'b1;
        end
        return m;
    endfunction

    // Successor step in the repeating loop.
    function automatic step_e step_next(input step_e s);
        return step_e'(s + 2'd1);
    endfunction

endpackage

// File: rtl/blink_sign_sync.sv
// Module: brings the asynchronous switch level into the clock domain.
// Assumes SYNC_STAGES >= 2; the chain clears on reset.
module blink_sign_sync #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_in,
    output logic sync_out
);

    logic [SYNC_STAGES-1:0] chain_q;

    // Shift the switch level through the flop chain.
    always_ff @(posedge clk) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= {chain_q[SYNC_STAGES-2:0], async_in};
    end

    assign sync_out = chain_q[SYNC_STAGES-1];

endmodule

// File: rtl/blink_sign_prescaler.sv
// Module: counts clock cycles and pulses a step tick once per interval.
// Assumes run is already synchronous; while run is low the count stays at zero.
module blink_sign_prescaler #(
    parameter int STEP_CYCLES = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic tick
);

    localparam int CW = (STEP_CYCLES > 1) ? $clog2(STEP_CYCLES) : 1;
    localparam logic [CW-1:0] LAST = CW'(STEP_CYCLES - 1);

    logic [CW-1:0] cnt_q;
    logic          at_end;

    assign at_end = (cnt_q == LAST);
    assign tick   = run && at_end;

    // Interval counter: clears when idle, wraps at the last cycle.
    always_ff @(posedge clk) begin
        if (!rst_n || !run) cnt_q <= '0;
        else if (at_end)    cnt_q <= '0;
        else                cnt_q <= cnt_q + 1'b1;
    end

endmodule

// File: rtl/blink_sign_fsm.sv
// Module: four-step pattern state plus the registered lamp decode.
// Assumes tick is only high while run is high.
module blink_sign_fsm
    import blink_sign_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run,
    input  logic              tick,
    output logic [LAMP_W-1:0] lamps
);

    step_e             step_q;
    step_e             step_d;
    logic [LAMP_W-1:0] lamps_q;

    // Next step: dark when idle, successor on a tick, else hold.
    always_comb begin
        if (!run)      step_d = STEP_DARK;
        else if (tick) step_d = step_next(step_q);
        else           step_d = step_q;
    end

    // Step register.
    always_ff @(posedge clk) begin
        if (!rst_n) step_q <= STEP_DARK;
        else        step_q <= step_d;
    end

    // Lamp register, loaded with the decode of the next step.
    always_ff @(posedge clk) begin
        if (!rst_n) lamps_q <= '0;
        else        lamps_q <= step_lamps(step_d);
    end

    assign lamps = lamps_q;

endmodule

// File: rtl/blink_sign_seq.sv
// Top: warning-sign lamp sequencer.
// Assumes CLK_HZ is a multiple of 1000 and the interval is at least one cycle.
module blink_sign_seq
    import blink_sign_pkg::*;
#(
    parameter int CLK_HZ      = 50_000_000,
    parameter int STEP_MS     = 500,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sw_on,
    output logic [LAMP_W-1:0] lamps
);

    localparam int STEP_CYCLES = (CLK_HZ / 1000) * STEP_MS;

    logic sw_sync;
    logic step_tick;

    blink_sign_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (sw_on),
        .sync_out (sw_sync)
    );

    blink_sign_prescaler #(.STEP_CYCLES(STEP_CYCLES)) u_presc (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (sw_sync),
        .tick  (step_tick)
    );

    blink_sign_fsm u_fsm (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (sw_sync),
        .tick  (step_tick),
        .lamps (lamps)
    );

endmodule

// File: rtl/blink_sign_seq_chk.sv
// Checker: temporal properties of the lamp sequencer, bound to the top.
module blink_sign_seq_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       sw_sync,
    input logic       step_tick,
    input logic [4:0] lamps
);

    function automatic logic [4:0] succ(input logic [4:0] v);
        case (v)
            5'b00000: succ = 5'b00011;
            5'b00011: succ = 5'b01111;
            5'b01111: succ = 5'b11111;
            default:  succ = 5'b00000;
        endcase
    endfunction

    // R7
    legal_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (lamps == 5'b00000) || (lamps == 5'b00011) ||
        (lamps == 5'b01111) || (lamps == 5'b11111));

    // R3
    step_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sw_sync && step_tick) |=> (lamps == succ($past(lamps))));

    // R4
    hold_between_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sw_sync && !step_tick) |=> $stable(lamps));

    // R5
    dark_when_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !sw_sync |=> (lamps == 5'b00000));

    // R5
    no_tick_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !sw_sync |-> !step_tick);

endmodule

bind blink_sign_seq blink_sign_seq_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .sw_sync   (sw_sync),
    .step_tick (step_tick),
    .lamps     (lamps)
);

// File: tb/tb_blink_sign_seq.sv
// Scoreboard bench: a model pushes expected lamp values, a monitor pops them.
module tb_blink_sign_seq;

    localparam int CLK_PERIOD = 10;
    localparam int CLK_HZ     = 8000;
    localparam int STEP_MS    = 1;
    localparam int STEP_N     = (CLK_HZ / 1000) * STEP_MS;
    localparam int SYNC_N     = 2;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       sw_on = 1'b0;
    logic [4:0] lamps;

    int total = 0;
    int bad   = 0;
    bit done  = 0;

    typedef struct {
        logic [4:0] code;
        string      tag;
    } exp_t;

    exp_t exp_q[$];

    blink_sign_seq #(.CLK_HZ(CLK_HZ), .STEP_MS(STEP_MS), .SYNC_STAGES(SYNC_N)) dut (
        .clk   (clk),
        .rst_n (rst_n),
        .sw_on (sw_on),
        .lamps (lamps)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic logic [4:0] pat(input int s);
        case (s)
            0: pat = 5'b00000;
            1: pat = 5'b00011;
            2: pat = 5'b01111;
            default: pat = 5'b11111;
        endcase
    endfunction

    task automatic push_exp(input logic [4:0] c, input string t);
        exp_t e;
        e.code = c;
        e.tag  = t;
        exp_q.push_back(e);
    endtask

    task automatic check(input string req, input logic [4:0] act, input logic [4:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: lamps=%b expected=%b at %0t", req, act, exp, $time);
        end
    endtask

    // Reference model built from the requirements (R1..R6).
    logic [SYNC_N-1:0] m_sync = '0;
    int m_cnt = 0;
    int m_st  = 0;
    bit m_en_prev = 0;
    always @(posedge clk) begin
        bit en;
        string t;
        if (!rst_n) begin
            m_sync = '0; m_cnt = 0; m_st = 0; m_en_prev = 0;
            push_exp(5'b00000, "R1");
        end else begin
            en = m_sync[SYNC_N-1];
            m_sync = {m_sync[SYNC_N-2:0], sw_on};
            if (!en) begin
                m_cnt = 0; m_st = 0; t = "R5";
            end else if (m_cnt == STEP_N-1) begin
                m_cnt = 0; m_st = (m_st + 1) % 4; t = "R3";
            end else begin
                m_cnt++;
                t = (m_st != 0) ? "R2" : "R4";
            end
            if (en != m_en_prev) t = "R6";
            m_en_prev = en;
            push_exp(pat(m_st), t);
        end
    end

    // Monitor: compare each cycle away from the active edge.
    always @(negedge clk) begin
        if (!done && exp_q.size() > 0) begin
            exp_t e;
            e = exp_q.pop_front();
            check(e.tag, lamps, e.code);
            total++;
            if (!(lamps == 5'b00000 || lamps == 5'b00011 ||
                  lamps == 5'b01111 || lamps == 5'b11111)) begin
                bad++;
                $display("FAIL R7: lamps=%b expected=legal code", lamps);
            end
        end
    end

    task automatic wait_cycles(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    // Driver: stimulus on falling edges only.
    initial begin
        wait_cycles(5);
        check("R1", lamps, 5'b00000);
        rst_n = 1'b1;
        wait_cycles(3);
        sw_on = 1'b1;
        wait_cycles(SYNC_N + STEP_N);
        check("R2", lamps, 5'b00011);
        wait_cycles(STEP_N * 9 + 3);
        sw_on = 1'b0;
        wait_cycles(4);
        check("R5", lamps, 5'b00000);
        sw_on = 1'b1;
        wait_cycles(STEP_N * 2 + 5);
        sw_on = 1'b0;
        wait_cycles(1);
        sw_on = 1'b1;
        wait_cycles(STEP_N * 6);
        rst_n = 1'b0;
        wait_cycles(3);
        check("R1", lamps, 5'b00000);
        rst_n = 1'b1;
        wait_cycles(STEP_N * 5 + 2);
        sw_on = 1'b0;
        wait_cycles(5);
        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    // Watchdog.
    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            done = 1;
            total++;
            bad++;
            $display("FAIL watchdog: run did not finish");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule